// File: doc/BRIEF.md
# Two-Bit Path Metric and Zero-Forcing Unit

This block stands in for the final stage of one list path in a list-based successive-cancellation polar decoder. From the four log-likelihoods that the stage before it produces, two for each half of the pair, it builds the extended path metrics of all four candidates for the next two decoded bits in a single step. This replaces the usual sequence of an f computation, a selection, a g computation and a second selection.

Each candidate metric is the incoming path metric plus one likelihood from the first half and one from the second half. The additions saturate. When a bit position carries no information, every candidate that sets that bit to 1 is forced to a reserved negative-infinity code. A downstream sorter then never keeps such a candidate. Results are registered and come out one cycle after the inputs, together with a valid strobe.

Metric width is `QCH_W + CODE_LOG2` bits. The incoming log-likelihoods are one bit narrower, matching the stage before. Negative infinity is the most negative two's-complement value of the metric width.

Top module: `pair_metric_unit`

## Requirements
- R1: Output slot c = {p,q} (p in bit 1, q in bit 0 of the index) of `metric_o` is at bits [c*MW +: MW]. It holds path_metric + a[p XOR q] + b[q]. So slot 0 uses a0+b0, slot 1 uses a1+b1, slot 2 uses a1+b0 and slot 3 uses a0+b1, with all values signed two's complement.
- R2: A sum above the largest metric value (2^(MW-1)-1) is clamped to that value.
- R3: A finite sum below -(2^(MW-1)-1) is clamped to -(2^(MW-1)-1). A finite input never yields the negative-infinity code -(2^(MW-1)).
- R4: A path metric input equal to the negative-infinity code gives the negative-infinity code in all four slots.
- R5: With `info_first_i` low (first bit frozen), slots 2 and 3 hold the negative-infinity code.
- R6: With `info_second_i` low (second bit frozen), slots 1 and 3 hold the negative-infinity code.
- R7: With both flags low and a finite path metric, only slot 0 holds a finite metric.
- R8: Inputs sampled with `in_valid_i` high appear on `metric_o` one clock later, with `out_valid_o` high in that cycle.
- R9: While `in_valid_i` is low, `metric_o` keeps its previous value and `out_valid_o` is low one cycle later.
- R10: After reset, `out_valid_o` is low and all four slots hold the negative-infinity code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input set is valid this cycle |
| ll_a0_i | input | LW | First-half log-likelihood for value 0 |
| ll_a1_i | input | LW | First-half log-likelihood for value 1 |
| ll_b0_i | input | LW | Second-half log-likelihood for value 0 |
| ll_b1_i | input | LW | Second-half log-likelihood for value 1 |
| path_metric_i | input | MW | Metric of the surviving path being extended |
| info_first_i | input | 1 | First bit of the pair is an information bit |
| info_second_i | input | 1 | Second bit of the pair is an information bit |
| out_valid_o | output | 1 | Registered metrics are new this cycle |
| metric_o | output | 4*MW | Four candidate metrics, slot c at [c*MW +: MW] |

## Verification
The sweep pushes sums past both ends of the metric range. A design without an upper clamp would wrap a large positive total into a strongly negative metric. One that clamped only to the raw minimum would hand a legal path the negative-infinity code, and the sorter would discard it. Path metrics at and next to negative infinity are mixed with all four frozen-flag combinations. This exposes a swapped likelihood pairing for slots 2 and 3, a mask applied to the wrong slots, and a negative-infinity input that returns to a finite value after the addition. Idle cycles between transactions show whether the registers hold or pick up whatever sits on the inputs.

// File: rtl/pmzf_pkg.sv
package pmzf_pkg;
  localparam int CAND_N = 4;

  // slot index {p,q}: first-half likelihood picked by p^q, second-half by q
  function automatic bit a_sel(input int idx);
    return bit'((idx >> 1) & 1) ^ bit'(idx & 1);
  endfunction

  function automatic bit b_sel(input int idx);
    return bit'(idx & 1);
  endfunction

  function automatic bit first_one(input int idx);
    return bit'((idx >> 1) & 1);
  endfunction

  function automatic bit second_one(input int idx);
    return bit'(idx & 1);
  endfunction
endpackage

// File: rtl/pmzf_cand_sum.sv
module pmzf_cand_sum #(
  parameter int MW = 7,
  parameter int LW = 6
) (
  input  logic [MW-1:0] pm_i,
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  output logic [MW-1:0] sum_o
);
  localparam int EW = MW + 2;
  localparam logic signed [EW-1:0] HI = EW'((2 ** (MW - 1)) - 1);
  localparam logic signed [EW-1:0] LO = -HI;
  localparam logic [MW-1:0] NEG_INF = {1'b1, {(MW-1){1'b0}}};

  logic signed [EW-1:0] pm_x, a_x, b_x, raw;

  always_comb begin
    pm_x = {{2{pm_i[MW-1]}}, pm_i};
    a_x  = {{(EW-LW){a_i[LW-1]}}, a_i};
    b_x  = {{(EW-LW){b_i[LW-1]}}, b_i};
    raw  = pm_x + a_x + b_x;
    if (pm_i == NEG_INF)  sum_o = NEG_INF;
    else if (raw > HI)    sum_o = HI[MW-1:0];
    else if (raw < LO)    sum_o = LO[MW-1:0];
    else                  sum_o = raw[MW-1:0];
  end
endmodule

// File: rtl/pmzf_force.sv
module pmzf_force
  import pmzf_pkg::*;
#(
  parameter int MW = 7
) (
  input  logic                 info_first_i,
  input  logic                 info_second_i,
  input  logic [CAND_N*MW-1:0] sum_i,
  output logic [CAND_N*MW-1:0] masked_o
);
  localparam logic [MW-1:0] NEG_INF = {1'b1, {(MW-1){1'b0}}};

  for (genvar c = 0; c < CAND_N; c++) begin : g_mask
    localparam bit F1 = first_one(c);
    localparam bit F2 = second_one(c);
    logic kill;
    assign kill = (F1 && !info_first_i) || (F2 && !info_second_i);
    assign masked_o[c*MW +: MW] = kill ? NEG_INF : sum_i[c*MW +: MW];
  end
endmodule

// File: rtl/pair_metric_unit.sv
module pair_metric_unit
  import pmzf_pkg::*;
#(
  parameter int QCH_W     = 3,
  parameter int CODE_LOG2 = 4,
  localparam int MW = QCH_W + CODE_LOG2,
  localparam int LW = MW - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [LW-1:0]        ll_a0_i,
  input  logic [LW-1:0]        ll_a1_i,
  input  logic [LW-1:0]        ll_b0_i,
  input  logic [LW-1:0]        ll_b1_i,
  input  logic [MW-1:0]        path_metric_i,
  input  logic                 info_first_i,
  input  logic                 info_second_i,
  output logic                 out_valid_o,
  output logic [CAND_N*MW-1:0] metric_o
);
  localparam logic [MW-1:0] NEG_INF = {1'b1, {(MW-1){1'b0}}};

  logic [CAND_N*MW-1:0] sums, masked;

  for (genvar c = 0; c < CAND_N; c++) begin : g_cand
    localparam bit SA = a_sel(c);
    localparam bit SB = b_sel(c);
    logic [LW-1:0] a_pick, b_pick;
    assign a_pick = SA ? ll_a1_i : ll_a0_i;
    assign b_pick = SB ? ll_b1_i : ll_b0_i;
    pmzf_cand_sum #(.MW(MW), .LW(LW)) u_sum (
      .pm_i (path_metric_i),
      .a_i  (a_pick),
      .b_i  (b_pick),
      .sum_o(sums[c*MW +: MW])
    );
  end

  pmzf_force #(.MW(MW)) u_force (
    .info_first_i (info_first_i),
    .info_second_i(info_second_i),
    .sum_i        (sums),
    .masked_o     (masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      metric_o    <= {CAND_N{NEG_INF}};
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) metric_o <= masked;
    end
  end

  assert_valid_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(metric_o)));
  assert_first_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !info_first_i) |=>
      (metric_o[2*MW +: MW] == NEG_INF && metric_o[3*MW +: MW] == NEG_INF));
  assert_second_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !info_second_i) |=>
      (metric_o[1*MW +: MW] == NEG_INF && metric_o[3*MW +: MW] == NEG_INF));
  assert_neg_inf_in_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && path_metric_i == NEG_INF) |=> (metric_o == {CAND_N{NEG_INF}}));
  assert_zero_pair_finite_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && path_metric_i != NEG_INF) |=> (metric_o[0 +: MW] != NEG_INF));
endmodule

// File: tb/sim_pair_metric_unit.sv
module sim_pair_metric_unit;
  localparam int QCH_W = 3;
  localparam int CODE_LOG2 = 4;
  localparam int MW = QCH_W + CODE_LOG2;
  localparam int LW = MW - 1;
  localparam int NEG = -(2 ** (MW - 1));
  localparam int HI = (2 ** (MW - 1)) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [LW-1:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
  logic [MW-1:0] pm = '0;
  logic inf1 = 1'b1, inf2 = 1'b1;
  logic out_valid;
  logic [4*MW-1:0] metric;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pair_metric_unit #(.QCH_W(QCH_W), .CODE_LOG2(CODE_LOG2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid),
    .ll_a0_i(a0), .ll_a1_i(a1), .ll_b0_i(b0), .ll_b1_i(b1),
    .path_metric_i(pm), .info_first_i(inf1), .info_second_i(inf2),
    .out_valid_o(out_valid), .metric_o(metric)
  );

  function automatic int slot(input int c);
    return int'($signed(metric[c*MW +: MW]));
  endfunction

  function automatic int wrap_ll(input int v);
    return (((v % 64) + 64) % 64) - 32;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int va0, input int va1, input int vb0, input int vb1,
                         input int vpm, input bit f1, input bit f2);
    int av[2], bv[2];
    av[0] = va0; av[1] = va1; bv[0] = vb0; bv[1] = vb1;
    @(negedge clk);
    in_valid = 1'b1;
    a0 = LW'(va0); a1 = LW'(va1); b0 = LW'(vb0); b1 = LW'(vb1);
    pm = MW'(vpm); inf1 = f1; inf2 = f2;
    @(negedge clk);
    check("R8", int'(out_valid), 1);
    for (int c = 0; c < 4; c++) begin
      int p, q, s, e;
      string r;
      p = (c >> 1) & 1;
      q = c & 1;
      s = vpm + av[p ^ q] + bv[q];
      r = "R1";
      if ((p == 1 && !f1) || (q == 1 && !f2)) begin
        e = NEG;
        r = (!f1 && !f2) ? "R7" : ((p == 1 && !f1) ? "R5" : "R6");
      end else if (vpm == NEG) begin
        e = NEG; r = "R4";
      end else if (s > HI) begin
        e = HI; r = "R2";
      end else if (s < -HI) begin
        e = -HI; r = "R3";
      end else begin
        e = s;
      end
      check(r, slot(c), e);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int pms[6];
    pms = '{NEG, NEG + 1, -40, 0, 30, HI};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10", int'(out_valid), 0);
    for (int c = 0; c < 4; c++) check("R10", slot(c), NEG);
    rst_ni = 1'b1;

    for (int x = -32; x < 32; x += 3) begin
      for (int y = -32; y < 32; y += 3) begin
        for (int k = 0; k < 6; k++) begin
          for (int f = 0; f < 4; f++) begin
            run_vec(x, y, wrap_ll(x * 7 + y * 3), wrap_ll(x * 5 - y * 11),
                    pms[k], bit'(f >> 1), bit'(f & 1));
          end
        end
      end
      // R9: idle cycle with disturbed inputs, outputs must hold
      begin
        int keep[4];
        for (int c = 0; c < 4; c++) keep[c] = slot(c);
        @(negedge clk);
        in_valid = 1'b0;
        a0 = LW'(x); a1 = LW'(-x - 1); b0 = LW'(5); b1 = LW'(-7);
        pm = MW'(3); inf1 = 1'b1; inf2 = 1'b1;
        @(negedge clk);
        check("R9", int'(out_valid), 0);
        for (int c = 0; c < 4; c++) check("R9", slot(c), keep[c]);
      end
    end

    // directed mapping: distinct likelihoods, every slot different (R1)
    run_vec(1, 2, 4, 8, 0, 1'b1, 1'b1);
    // extremes (R2, R3)
    run_vec(31, 31, 31, 31, HI, 1'b1, 1'b1);
    run_vec(-32, -32, -32, -32, NEG + 1, 1'b1, 1'b1);
    // both frozen with finite metric (R7)
    run_vec(-3, 5, -2, 9, 10, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule